// File: doc/BRIEF.md
# Floating-point exception sequencer

This block follows every floating-point operation through a fixed-depth pipeline. It produces the control strobes that sit around the arithmetic datapath. The arithmetic itself is outside the block. An issued operation carries a tag and an operation class.

A few stages after issue, a coprocessor-enable input is checked. If the enable is clear, the operation is cancelled at once and a precise exception pulse is raised that carries the operation's tag. If the enable is set, the operation continues and raises four strobes at fixed later stages:
- an operand-read strobe;
- a result-valid strobe that carries the tag;
- a flag-post strobe that carries the exception flags for that class;
- a late imprecise-error pulse, raised only when a posted flag is also enabled.

The imprecise pulse carries no tag, so software cannot tell which operation caused it. A cancelled operation becomes a bubble. A new operation may enter on every cycle. The stage numbers are parameters. By default the gate is at stage 3, the operand read at 10 and the result at 13. The flags follow at 14 and the imprecise report at 15.

Timing convention: an operation issued in cycle t occupies stage k in cycle t+k. Each input that a stage consumes is sampled in the cycle before that stage's output appears.

Top module: `fpx_seq`

## Requirements
- R1: While reset is held, and in the cycle after it, prec_exc, opnd_rd, res_vld, flag_stb and imp_err are low, and flag_vec is zero.
- R2: An operation issued in cycle t whose cp_en is high in cycle t+2 raises no precise exception and goes on to the later stages.
- R3: An operation issued in cycle t whose cp_en is low in cycle t+2 raises prec_exc for exactly cycle t+3, with prec_tag equal to its tag. It then causes no opnd_rd, res_vld, flag_stb or imp_err.
- R4: A surviving operation issued in cycle t raises opnd_rd in cycle t+10.
- R5: A surviving operation issued in cycle t raises res_vld in cycle t+13, with res_tag equal to its tag.
- R6: For a flag-posting class, flag_stb is high in cycle t+14. flag_vec is then dp_flags (sampled in cycle t+13) masked by the class. flag_vec is zero whenever flag_stb is low. Flag bits: 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid. Class full (iss_opc 0) passes all five bits.
- R7: Class no-flag (iss_opc 1) never raises flag_stb or imp_err, whatever dp_flags and flag_en hold.
- R8: Class divide-step (iss_opc 2) posts overflow, underflow, inexact and divide-by-zero, and always clears the invalid bit (bit 4).
- R9: Class add/sub (iss_opc 3) always clears the underflow bit (bit 1).
- R10: imp_err is high in cycle t+15 exactly when flag_stb was high in cycle t+14 and flag_vec AND flag_en (flag_en sampled in cycle t+14) is non-zero.
- R11: An operation may issue on every cycle. A squashed operation does not change the timing or the outputs of its neighbours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | An operation issues this cycle |
| iss_tag | input | TAG_W | Tag of the issuing operation |
| iss_opc | input | 2 | Operation class: 0 full, 1 no-flag, 2 divide-step, 3 add/sub |
| cp_en | input | 1 | Coprocessor enable, checked for the operation at stage GATE_STG-1 |
| dp_flags | input | 5 | Raw flags from the datapath for the operation at the result stage |
| flag_en | input | 5 | Exception enables, applied to the operation at the flag stage |
| prec_exc | output | 1 | Precise exception pulse (operation squashed) |
| prec_tag | output | TAG_W | Tag of the squashed operation |
| opnd_rd | output | 1 | Operand and round-mode read strobe |
| res_vld | output | 1 | Result-valid strobe |
| res_tag | output | TAG_W | Tag of the completing operation |
| flag_stb | output | 1 | Flag-post strobe |
| flag_vec | output | 5 | Class-masked flags to accumulate |
| imp_err | output | 1 | Deferred imprecise-error pulse |

## Verification
The hardest case to reach is an imprecise pulse that is correctly raised or correctly withheld. For one operation, three inputs must line up: the enable two cycles after issue, the datapath flags thirteen cycles after, and the enable mask fourteen cycles after. Each of those cycles is shared with other operations in flight at other stages. The bench therefore schedules every input per cycle in arrays before the run. It places directed cases first:
- all flags raised but none enabled;
- invalid-only flags on a divide-step;
- underflow-only flags on an add;
- flags on a no-flag class;
- a single enabled overflow.

It then fills a long back-to-back random stretch in which about one operation in five is squashed. A model that reads those same arrays predicts every output in every cycle.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  localparam int NFLAG = 5;

  // flag bit positions
  localparam int FLG_INEXACT = 0;
  localparam int FLG_UNDER   = 1;
  localparam int FLG_OVER    = 2;
  localparam int FLG_DIVZ    = 3;
  localparam int FLG_INVAL   = 4;

  typedef enum logic [1:0] {
    OPC_FULL    = 2'd0,
    OPC_NOFLAG  = 2'd1,
    OPC_DIVSTEP = 2'd2,
    OPC_ADDSUB  = 2'd3
  } opc_e;

  // which raw flags each class is allowed to post
  function automatic logic [NFLAG-1:0] class_mask(input opc_e c);
    logic [NFLAG-1:0] m;
    m = '1;
    case (c)
      OPC_NOFLAG:  m = '0;
      OPC_DIVSTEP: m[FLG_INVAL] = 1'b0;
      OPC_ADDSUB:  m[FLG_UNDER] = 1'b0;
      default:     m = '1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/fpx_pipe.sv
// Fixed-depth delay line: a valid bit with reset, and a data word without
// reset so that the data can map to shift-register primitives.
module fpx_pipe #(
  parameter int DEPTH = 1,
  parameter int W     = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign out_vld = in_vld;
      assign out_dat = in_dat;
    end else begin : g_reg
      logic [DEPTH-1:0] v_q;
      logic [W-1:0]     d_q [DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          v_q <= '0;
        end else begin
          v_q[0] <= in_vld;
          for (int i = 1; i < DEPTH; i++) v_q[i] <= v_q[i-1];
        end
      end

      always_ff @(posedge clk) begin
        d_q[0] <= in_dat;
        for (int i = 1; i < DEPTH; i++) d_q[i] <= d_q[i-1];
      end

      assign out_vld = v_q[DEPTH-1];
      assign out_dat = d_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/fpx_gate.sv
// Capability check: either pass the op on, or squash it with a precise,
// tagged exception. Both results are registered.
module fpx_gate #(
  parameter int W  = 6,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [W-1:0]  in_dat,
  input  logic          cp_en,
  output logic          pass_vld,
  output logic [W-1:0]  pass_dat,
  output logic          exc,
  output logic [TW-1:0] exc_tag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_vld <= 1'b0;
      exc      <= 1'b0;
    end else begin
      pass_vld <= in_vld & cp_en;
      exc      <= in_vld & ~cp_en;
    end
  end

  always_ff @(posedge clk) begin
    pass_dat <= in_dat;
    exc_tag  <= in_dat[W-1 -: TW];
  end

  // squash and pass are exclusive outcomes of one op
  assert_gate_excl_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pass_vld, exc}));

  // every outcome comes from a real issued op
  assert_gate_origin_R2: assert property (@(posedge clk) disable iff (rst)
    (pass_vld || exc) |-> $past(in_vld));

endmodule

// File: rtl/fpx_flag.sv
// Flag stage (class masking) followed by the imprecise-report stage.
module fpx_flag
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             res_vld,
  input  logic [1:0]       res_opc,
  input  logic [NFLAG-1:0] raw_flags,
  input  logic [NFLAG-1:0] flag_en,
  output logic             stb,
  output logic [NFLAG-1:0] vec,
  output logic             err
);

  opc_e opc;
  logic posts;

  assign opc   = opc_e'(res_opc);
  assign posts = res_vld && (opc != OPC_NOFLAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      stb <= 1'b0;
      vec <= '0;
      err <= 1'b0;
    end else begin
      stb <= posts;
      vec <= posts ? (raw_flags & class_mask(opc)) : '0;
      err <= stb && (|(vec & flag_en));
    end
  end

  assert_err_follows_stb_R10: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(stb));

  assert_noflag_silent_R7: assert property (@(posedge clk) disable iff (rst)
    $past(res_vld && opc == OPC_NOFLAG) |-> !stb);

  assert_divstep_no_inval_R8: assert property (@(posedge clk) disable iff (rst)
    (stb && $past(opc == OPC_DIVSTEP)) |-> !vec[FLG_INVAL]);

  assert_addsub_no_under_R9: assert property (@(posedge clk) disable iff (rst)
    (stb && $past(opc == OPC_ADDSUB)) |-> !vec[FLG_UNDER]);

  assert_vec_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !stb |-> (vec == '0));

endmodule

// File: rtl/fpx_seq.sv
// Two-tier floating-point exception sequencer.
module fpx_seq
  import fpx_pkg::*;
#(
  parameter int TAG_W      = 4,
  parameter int GATE_STG   = 3,
  parameter int READ_STG   = 10,
  parameter int RESULT_STG = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_vld,
  input  logic [TAG_W-1:0] iss_tag,
  input  logic [1:0]       iss_opc,
  input  logic             cp_en,
  input  logic [4:0]       dp_flags,
  input  logic [4:0]       flag_en,
  output logic             prec_exc,
  output logic [TAG_W-1:0] prec_tag,
  output logic             opnd_rd,
  output logic             res_vld,
  output logic [TAG_W-1:0] res_tag,
  output logic             flag_stb,
  output logic [4:0]       flag_vec,
  output logic             imp_err
);

  localparam int DW    = TAG_W + 2;
  localparam int PRE_D = GATE_STG - 1;
  localparam int RD_D  = READ_STG - GATE_STG;
  localparam int RES_D = RESULT_STG - READ_STG;

  logic          pre_vld,  gate_vld,  rd_vld,  res_v;
  logic [DW-1:0] pre_dat,  gate_dat,  rd_dat,  res_dat;

  // issue -> stage GATE_STG-1
  fpx_pipe #(.DEPTH(PRE_D), .W(DW)) u_pre (
    .clk(clk), .rst(rst), .in_vld(iss_vld), .in_dat({iss_tag, iss_opc}),
    .out_vld(pre_vld), .out_dat(pre_dat));

  // stage GATE_STG: precise capability check
  fpx_gate #(.W(DW), .TW(TAG_W)) u_gate (
    .clk(clk), .rst(rst), .in_vld(pre_vld), .in_dat(pre_dat), .cp_en(cp_en),
    .pass_vld(gate_vld), .pass_dat(gate_dat), .exc(prec_exc), .exc_tag(prec_tag));

  // -> stage READ_STG
  fpx_pipe #(.DEPTH(RD_D), .W(DW)) u_rd (
    .clk(clk), .rst(rst), .in_vld(gate_vld), .in_dat(gate_dat),
    .out_vld(rd_vld), .out_dat(rd_dat));

  // -> stage RESULT_STG
  fpx_pipe #(.DEPTH(RES_D), .W(DW)) u_res (
    .clk(clk), .rst(rst), .in_vld(rd_vld), .in_dat(rd_dat),
    .out_vld(res_v), .out_dat(res_dat));

  // stages RESULT_STG+1 and RESULT_STG+2
  fpx_flag u_flag (
    .clk(clk), .rst(rst), .res_vld(res_v), .res_opc(res_dat[1:0]),
    .raw_flags(dp_flags), .flag_en(flag_en),
    .stb(flag_stb), .vec(flag_vec), .err(imp_err));

  assign opnd_rd = rd_vld;
  assign res_vld = res_v;
  assign res_tag = res_dat[DW-1:2];

  assert_stb_after_result_R6: assert property (@(posedge clk) disable iff (rst)
    flag_stb |-> $past(res_vld));

  assert_err_has_flags_R10: assert property (@(posedge clk) disable iff (rst)
    imp_err |-> $past(|flag_vec));

endmodule

// File: tb/tb_fpx_seq.sv
`timescale 1ns/1ps
module tb_fpx_seq;

  localparam int N = 3000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       iss_vld = 1'b0;
  logic [3:0] iss_tag = '0;
  logic [1:0] iss_opc = '0;
  logic       cp_en = 1'b0;
  logic [4:0] dp_flags = '0;
  logic [4:0] flag_en = '0;
  logic       prec_exc, opnd_rd, res_vld, flag_stb, imp_err;
  logic [3:0] prec_tag, res_tag;
  logic [4:0] flag_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic       iv [N];
  logic [3:0] tg [N];
  logic [1:0] oc [N];
  logic       ce [N];
  logic [4:0] fl [N];
  logic [4:0] en [N];

  always #2.5 clk = ~clk;

  fpx_seq dut (
    .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_tag(iss_tag), .iss_opc(iss_opc),
    .cp_en(cp_en), .dp_flags(dp_flags), .flag_en(flag_en),
    .prec_exc(prec_exc), .prec_tag(prec_tag), .opnd_rd(opnd_rd),
    .res_vld(res_vld), .res_tag(res_tag), .flag_stb(flag_stb),
    .flag_vec(flag_vec), .imp_err(imp_err));

  // ---------------- reference model ----------------
  function automatic logic [4:0] mask_of(input logic [1:0] c);
    case (c)
      2'd1:    return 5'b00000;
      2'd2:    return 5'b01111;
      2'd3:    return 5'b11101;
      default: return 5'b11111;
    endcase
  endfunction

  function automatic bit alive(input int t);
    if (t < 0 || t + 2 >= N) return 0;
    return iv[t] && ce[t+2];
  endfunction

  function automatic bit e_exc(input int n);
    int t = n - 3;
    if (t < 0) return 0;
    return iv[t] && !ce[n-1];
  endfunction

  function automatic bit e_stb(input int n);
    int t = n - 14;
    if (t < 0) return 0;
    return alive(t) && oc[t] != 2'd1;
  endfunction

  function automatic logic [4:0] e_vec(input int n);
    if (!e_stb(n)) return 5'b0;
    return fl[n-1] & mask_of(oc[n-14]);
  endfunction

  function automatic bit e_err(input int n);
    if (n < 1) return 0;
    return e_stb(n-1) && (|(e_vec(n-1) & en[n-1]));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string flag_req(input int n);
    int t = n - 14;
    if (t < 0) return "R6";
    case (oc[t])
      2'd1: return "R7";
      2'd2: return "R8";
      2'd3: return "R9";
      default: return "R6";
    endcase
  endfunction

  // ---------------- stimulus plan ----------------
  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin
      iv[i] = 0; tg[i] = 4'(i); oc[i] = 0; ce[i] = 1; fl[i] = 0; en[i] = 0;
    end
    // directed corner cases
    iv[10] = 1; oc[10] = 0; fl[23] = 5'b11111; en[24] = 5'b00000; // R10 none enabled
    iv[11] = 1; oc[11] = 0; ce[13] = 0; fl[24] = 5'b11111;         // R3 squash
    iv[12] = 1; oc[12] = 1; fl[25] = 5'b11111; en[26] = 5'b11111;  // R7
    iv[13] = 1; oc[13] = 2; fl[26] = 5'b10000; en[27] = 5'b11111;  // R8
    iv[14] = 1; oc[14] = 3; fl[27] = 5'b00010; en[28] = 5'b11111;  // R9
    iv[15] = 1; oc[15] = 0; fl[28] = 5'b00100; en[29] = 5'b00100;  // R10 fires
    // alternating squash burst, R11
    for (int i = 16; i < 24; i++) begin
      iv[i] = 1; oc[i] = 2'(i); ce[i+2] = (i % 2 == 0);
      fl[i+13] = 5'b11111; en[i+14] = 5'b00001;
    end
    // random back-to-back region
    for (int i = 40; i < N - 20; i++) begin
      iv[i] = ($urandom % 4) != 0;
      tg[i] = 4'($urandom);
      oc[i] = 2'($urandom);
    end
    for (int i = 42; i < N; i++) begin
      ce[i] = ($urandom % 5) != 0;
      fl[i] = 5'($urandom);
      en[i] = 5'($urandom);
    end
  end

  // ---------------- run ----------------
  initial begin
    #1;
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      if (n >= 1 && n <= 4) begin
        chk(!prec_exc && !opnd_rd && !res_vld && !flag_stb && !imp_err && flag_vec == 0,
            "R1", {prec_exc, opnd_rd, res_vld, flag_stb, imp_err}, 0);
      end else if (n > 4) begin
        chk(prec_exc == e_exc(n), "R3", prec_exc, e_exc(n));
        if (e_exc(n)) chk(prec_tag == tg[n-3], "R3", prec_tag, tg[n-3]);
        chk(opnd_rd == alive(n-10), "R4/R11", opnd_rd, alive(n-10));
        chk(res_vld == alive(n-13), "R2/R5", res_vld, alive(n-13));
        if (alive(n-13)) chk(res_tag == tg[n-13], "R5", res_tag, tg[n-13]);
        chk(flag_stb == e_stb(n), flag_req(n), flag_stb, e_stb(n));
        chk(flag_vec == e_vec(n), flag_req(n), flag_vec, e_vec(n));
        chk(imp_err == e_err(n), "R10", imp_err, e_err(n));
      end
      // drive inputs for cycle n
      rst      = (n < 4);
      iss_vld  = iv[n];
      iss_tag  = tg[n];
      iss_opc  = oc[n];
      cp_en    = ce[n];
      dp_flags = fl[n];
      flag_en  = en[n];
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule